// File: doc/BRIEF.md
# Pull Resistor Control Sequencer

This block keeps the pull resistor setting of every pin in a group of banks (two banks of 32 pins by default) and drives a pull-up enable and a pull-down enable for each pin. Software does not write a pull field per pin. It loads one shared 2-bit pull code into a control register. It then raises per-pin strobe bits in the bank strobe registers. Each pin whose strobe bit goes from 0 to 1 copies the shared code into its own latch. Every other pin keeps what it held before.

The expected programming order is as follows. Load the code. Wait a setup time. Raise the strobe bit. Wait a hold time. Return the code to 0. Drop the strobe bit. The block counts clock cycles from the last control write. If a strobe rises before the setup time has passed, it sets a sticky flag. Software can read that flag and clear it. The register interface is a plain 32-bit write/read bus. Read data is combinational on the address.

Top module: `pull_seq`

## Requirements
- R1: After reset every pin has both pull enables low, the control register reads 0, both strobe registers read 0 and `setup_err` is low.
- R2: A write to address 0x94 stores bits [1:0] as the pull code. Reading 0x94 returns the code in bits [1:0] and the setup flag in bit 31.
- R3: Consider a write to a strobe register (0x98 for pins 0-31, 0x9C for pins 32-63, where bit n%32 selects pin n). Each bit that goes from 0 to 1 copies the current code into that pin, visible on the outputs in the cycle after the write. Code 1 enables pull-down, code 2 enables pull-up and code 0 enables neither.
- R4: A pin whose strobe bit does not go from 0 to 1 keeps its pull state. This covers bits held at 1 across a rewrite, bits in the other bank, and control writes.
- R5: A pin keeps its pull state after its strobe bit returns to 0 and after the code returns to 0.
- R6: Code 3 is treated as no pull. A pin strobed with it drives both enables low.
- R7: Pull-up enable and pull-down enable of a pin are never high together.
- R8: Let d be the number of clock cycles from a control write to a strobe write that raises at least one bit. If d is less than SETUP_CYCLES (default 150), `setup_err` and bit 31 of 0x94 become 1 and stay 1. If d is equal to or greater than SETUP_CYCLES, the flag is not set. If there has been no control write since reset, the flag is not set.
- R9: A control write with bit 31 set clears the setup flag in the following cycle.
- R10: Each strobe register reads back the value last written to it, zero-extended.
- R11: A write to any other address changes no pull output, no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address for the write or read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pull_up_en | output | 64 | Pull-up enable, one bit per pin |
| pull_dn_en | output | 64 | Pull-down enable, one bit per pin |
| setup_err | output | 1 | Sticky setup-time violation flag |

## Verification
Random sequences mix control writes of all four codes, sparse and dense strobe masks on both banks, idle gaps shorter and longer than the setup window, and stray writes to unmapped addresses. A bench model predicts every pin's state. Re-writing a mask that keeps some bits at 1 separates edge capture from level capture. Strobing one bank while the other stays still shows that the banks are independent. Directed cases place a strobe exactly one cycle short of the setup window and exactly at it, to find the boundary of the violation check. Code 3 separates the reserved decode from pull-up.

// File: rtl/pull_seq_pkg.sv
// Shared types for the pull resistor sequencer.
package pull_seq_pkg;

    // Shared pull code as written to the control register.
    typedef enum logic [1:0] {
        PULL_NONE = 2'd0,
        PULL_DOWN = 2'd1,
        PULL_UP   = 2'd2,
        PULL_RSVD = 2'd3
    } pull_code_e;

    // Decoded pair of pad enables.
    typedef struct packed {
        logic up;
        logic dn;
    } pull_en_t;

    // Maps a code to enables; the reserved code means no pull.
    function automatic pull_en_t decode_pull(input pull_code_e c);
        pull_en_t e;
        e.up = (c == PULL_UP);
        e.dn = (c == PULL_DOWN);
        return e;
    endfunction

endpackage

// File: rtl/pull_ctrl.sv
// Holds the shared pull code and checks the setup time.
// Assumes the control write and the strobe writes never occur in the same
// cycle (one bus address per cycle). A cycle counter restarts at 1 on each
// control write and saturates at SETUP_CYCLES. A strobe rise seen while the
// counter is below SETUP_CYCLES sets a sticky flag.
module pull_ctrl
    import pull_seq_pkg::*;
#(
    parameter int SETUP_CYCLES = 150
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [1:0] ctrl_code,
    input  logic       err_clr,
    input  logic       strobe_rise,
    output pull_code_e code,
    output logic       err
);
    localparam int CW = $clog2(SETUP_CYCLES + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(SETUP_CYCLES);

    logic [CW-1:0] since_wr;

    // Stores the shared code on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code <= PULL_NONE;
        else if (ctrl_wr)
            code <= pull_code_e'(ctrl_code);
    end

    // Counts cycles since the last control write, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_wr <= CNT_MAX;
        else if (ctrl_wr)
            since_wr <= CW'(1);
        else if (since_wr < CNT_MAX)
            since_wr <= since_wr + CW'(1);
    end

    // Sets the sticky violation flag on an early strobe; software clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (ctrl_wr && err_clr)
            err <= 1'b0;
        else if (strobe_rise && (since_wr < CNT_MAX))
            err <= 1'b1;
    end

endmodule

// File: rtl/pull_bank.sv
// One bank of pins: the strobe register plus one pull latch per pin.
// A pin latch copies the shared code when its strobe bit goes 0 -> 1 in a
// write. Assumes the code input is stable during that write cycle.
module pull_bank
    import pull_seq_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [PINS-1:0] wbits,
    input  pull_code_e      code,
    output logic [PINS-1:0] strobe_q,
    output logic [PINS-1:0] up_en,
    output logic [PINS-1:0] dn_en,
    output logic            any_rise
);
    logic [PINS-1:0] rise;

    // Finds bits that go from 0 to 1 in this write.
    always_comb rise = wr ? (wbits & ~strobe_q) : '0;
    assign any_rise = |rise;

    // Holds the strobe bits as last written.
    always_ff @(posedge clk) begin
        if (!rst_n)
            strobe_q <= '0;
        else if (wr)
            strobe_q <= wbits;
    end

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        pull_code_e lat;
        pull_en_t   en;

        // Captures the shared code on this pin's strobe rise.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lat <= PULL_NONE;
            else if (rise[p])
                lat <= code;
        end

        // Decodes the latched code into the two enables.
        always_comb en = decode_pull(lat);
        assign up_en[p] = en.up;
        assign dn_en[p] = en.dn;
    end

endmodule

// File: rtl/pull_seq.sv
// Top of the pull resistor sequencer: address decode, read mux, shared
// control and one pull_bank per bank. Bank b's strobe register sits at
// STROBE_BASE + 4*b. Assumes one bus access per cycle.
module pull_seq
    import pull_seq_pkg::*;
#(
    parameter int          BANKS        = 2,
    parameter int          PINS         = 32,
    parameter int          DW           = 32,
    parameter int          AW           = 8,
    parameter logic [7:0]  CTRL_ADDR    = 8'h94,
    parameter logic [7:0]  STROBE_BASE  = 8'h98,
    parameter int          SETUP_CYCLES = 150
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [AW-1:0]         bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    output logic [BANKS*PINS-1:0] pull_up_en,
    output logic [BANKS*PINS-1:0] pull_dn_en,
    output logic                  setup_err
);
    localparam int NPINS   = BANKS * PINS;
    localparam int ERR_BIT = DW - 1;

    pull_code_e       code;
    logic             ctrl_sel;
    logic [BANKS-1:0] bank_sel;
    logic [BANKS-1:0] bank_rise;
    logic [PINS-1:0]  strobe_q [BANKS];

    // Decodes the control register address.
    always_comb ctrl_sel = (bus_addr == AW'(CTRL_ADDR));

    pull_ctrl #(.SETUP_CYCLES(SETUP_CYCLES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (bus_wr && ctrl_sel),
        .ctrl_code   (bus_wdata[1:0]),
        .err_clr     (bus_wdata[ERR_BIT]),
        .strobe_rise (|bank_rise),
        .code        (code),
        .err         (setup_err)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        // Decodes this bank's strobe register address.
        always_comb bank_sel[b] = (bus_addr == AW'(STROBE_BASE + 4 * b));

        pull_bank #(.PINS(PINS)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (bus_wr && bank_sel[b]),
            .wbits    (bus_wdata[PINS-1:0]),
            .code     (code),
            .strobe_q (strobe_q[b]),
            .up_en    (pull_up_en[b*PINS +: PINS]),
            .dn_en    (pull_dn_en[b*PINS +: PINS]),
            .any_rise (bank_rise[b])
        );
    end

    // Selects read data by address; unmapped addresses read 0.
    always_comb begin
        bus_rdata = '0;
        if (ctrl_sel) begin
            bus_rdata[1:0]     = code;
            bus_rdata[ERR_BIT] = setup_err;
        end
        for (int b = 0; b < BANKS; b++)
            if (bank_sel[b])
                bus_rdata = DW'(strobe_q[b]);
    end

endmodule

// File: rtl/pull_seq_chk.sv
// Checker for pull_seq: port-level temporal properties, bound to the top.
module pull_seq_chk #(
    parameter int         BANKS       = 2,
    parameter int         PINS        = 32,
    parameter int         DW          = 32,
    parameter int         AW          = 8,
    parameter logic [7:0] CTRL_ADDR   = 8'h94,
    parameter logic [7:0] STROBE_BASE = 8'h98
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic [AW-1:0]         bus_addr,
    input logic [DW-1:0]         bus_wdata,
    input logic [BANKS*PINS-1:0] pull_up_en,
    input logic [BANKS*PINS-1:0] pull_dn_en,
    input logic                  setup_err
);
    logic is_ctrl, is_mapped;

    // Classifies the current bus address.
    always_comb begin
        is_ctrl   = (bus_addr == AW'(CTRL_ADDR));
        is_mapped = is_ctrl;
        for (int b = 0; b < BANKS; b++)
            if (bus_addr == AW'(STROBE_BASE + 4 * b)) is_mapped = 1'b1;
    end

    AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_up_en & pull_dn_en) == '0); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(pull_up_en) && $stable(pull_dn_en)); // R5

    AST_CTRL_WR_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_ctrl) |=> $stable(pull_up_en) && $stable(pull_dn_en)); // R4

    AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !is_mapped) |=> $stable(pull_up_en) && $stable(pull_dn_en)
                                   && $stable(setup_err)); // R11

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_err && !(bus_wr && is_ctrl && bus_wdata[DW-1])) |=> setup_err); // R8

    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_ctrl && bus_wdata[DW-1]) |=> !setup_err); // R9

endmodule

bind pull_seq pull_seq_chk #(
    .BANKS(BANKS), .PINS(PINS), .DW(DW), .AW(AW),
    .CTRL_ADDR(CTRL_ADDR), .STROBE_BASE(STROBE_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pull_up_en (pull_up_en),
    .pull_dn_en (pull_dn_en),
    .setup_err  (setup_err)
);

// File: tb/pull_seq_test.sv
// Bench for pull_seq: directed corners plus seeded random sequences.
module pull_seq_test;
    localparam int SETUP = 20;
    localparam int NP    = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] pull_up_en, pull_dn_en;
    logic        setup_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [1:0]  m_code [NP];
    logic [31:0] m_strobe [2];
    logic [1:0]  m_ctrl;
    logic        m_err;
    int          m_since;

    pull_seq #(.SETUP_CYCLES(SETUP)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en), .setup_err(setup_err)
    );

    always #5 clk = ~clk;

    function automatic logic [NP-1:0] exp_up();
        logic [NP-1:0] v;
        for (int p = 0; p < NP; p++) v[p] = (m_code[p] == 2'd2);
        return v;
    endfunction

    function automatic logic [NP-1:0] exp_dn();
        logic [NP-1:0] v;
        for (int p = 0; p < NP; p++) v[p] = (m_code[p] == 2'd1);
        return v;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < NP; p++) m_code[p] = 2'd0;
        m_strobe[0] = '0; m_strobe[1] = '0;
        m_ctrl = 2'd0; m_err = 1'b0; m_since = SETUP;
    endtask

    // One write; model updated from the requirements, one clock edge consumed.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] rise;
        if (a == 8'h98 || a == 8'h9C) begin
            int b = (a == 8'h98) ? 0 : 1;
            rise = d & ~m_strobe[b];
            if (rise != 0 && m_since < SETUP) m_err = 1'b1;
            for (int i = 0; i < 32; i++)
                if (rise[i]) m_code[b*32+i] = m_ctrl;
            m_strobe[b] = d;
        end
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        if (a == 8'h94) begin
            m_ctrl = d[1:0];
            if (d[31]) m_err = 1'b0;
            m_since = 1;
        end else if (m_since < SETUP) m_since++;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            if (m_since < SETUP) m_since++;
        end
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    // Full comparison of outputs and readable registers against the model.
    task automatic check_all(input string tag);
        logic [31:0] r;
        check({tag, " R3 pull-up"}, pull_up_en, exp_up());
        check({tag, " R3 pull-down"}, pull_dn_en, exp_dn());
        check({tag, " R7 exclusive"}, pull_up_en & pull_dn_en, '0);
        check({tag, " R8 setup_err"}, 64'(setup_err), 64'(m_err));
        rd(8'h94, r);
        check({tag, " R2 ctrl readback"}, 64'(r), 64'({m_err, 29'd0, m_ctrl}));
        rd(8'h98, r);
        check({tag, " R10 strobe0"}, 64'(r), 64'(m_strobe[0]));
        rd(8'h9C, r);
        check({tag, " R10 strobe1"}, 64'(r), 64'(m_strobe[1]));
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        check_all("R1 reset");

        // R8: strobe with no control write since reset raises no flag.
        wr(8'h98, 32'h1);
        check_all("R8 no-ctrl-yet");
        wr(8'h98, 32'h0);

        // R3: pull-up on pin 5 with correct timing; R5 holds after cleanup.
        wr(8'h94, 32'd2);
        idle(SETUP);
        wr(8'h98, 32'h20);
        check_all("R3 pin5 up");
        idle(3);
        wr(8'h94, 32'd0);
        wr(8'h98, 32'h0);
        check_all("R5 hold after cleanup");

        // R3/R4: pull-down on pin 40 leaves bank 0 alone.
        wr(8'h94, 32'd1);
        idle(SETUP);
        wr(8'h9C, 32'h100);
        check_all("R4 other bank");

        // R4: bit 8 held at 1 across a rewrite is not re-captured.
        wr(8'h94, 32'd2);
        idle(SETUP);
        wr(8'h9C, 32'h101);
        check_all("R4 held bit");

        // R6: reserved code gives no pull.
        wr(8'h94, 32'd3);
        idle(SETUP);
        wr(8'h98, 32'h20);
        check_all("R6 reserved");

        // R8 boundary: one cycle short sets the flag.
        wr(8'h98, 32'h0);
        wr(8'h94, 32'd1);
        idle(SETUP - 2);
        wr(8'h98, 32'h4);
        check_all("R8 short by one");
        // R9: clear via bit 31.
        wr(8'h94, 32'h8000_0000);
        check_all("R9 clear");
        // R8 boundary: exactly SETUP cycles raises no flag.
        wr(8'h98, 32'h0);
        wr(8'h94, 32'd2);
        idle(SETUP - 1);
        wr(8'h98, 32'h4);
        check_all("R8 exact");

        // R11: unmapped write changes nothing.
        wr(8'h90, 32'hFFFF_FFFF);
        wr(8'hA0, 32'hFFFF_FFFF);
        check_all("R11 unmapped");
        rd(8'hA0, r);
        check("R11 unmapped reads 0", 64'(r), 64'd0);

        // Random mix.
        for (int n = 0; n < 400; n++) begin
            int op = $urandom_range(0, 9);
            if (op < 2)
                wr(8'h94, {($urandom_range(0, 3) == 0), 29'd0, 2'($urandom_range(0, 3))});
            else if (op < 6)
                wr($urandom_range(0, 1) ? 8'h98 : 8'h9C,
                   ($urandom_range(0, 1) ? $urandom() & $urandom() & $urandom() : $urandom()));
            else if (op < 9)
                idle($urandom_range(0, SETUP + 5));
            else
                wr(8'h80 + 8'($urandom_range(0, 7)), $urandom());
            check_all("rnd");
        end

        done = 1'b1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule